// File: doc/BRIEF.md
# Serial Bit-Rate Generator

This block turns a fast core clock into the bit timing for a synchronous serial shift engine. It divides in two stages. The first stage is an even prescaler. The second stage divides by one more than an 8-bit rate value. The total ratio of core clock to serial clock is the product of the two, so it spans 2 to 65024. Everything stays in the core clock domain. The outputs are a serial clock level plus single-cycle strobes, which the shift engine uses as clock enables. No derived clock net is ever produced.

The serial clock idles low and has an even duty cycle. After enable rises, the first half-period is low and the first edge is a rising edge. The divisor inputs are captured while the block is disabled, and afterwards only at the end of a full serial period. A change made mid-period therefore cannot distort the bit in flight. All four outputs are control strobes and levels with no data payload, so they carry no handshake.

Top module: `serial_rate_gen`

## Requirements
- R1: With an effective prescale value P and rate value R, one serial clock period lasts exactly P*(R+1) core cycles, and this holds for every period in a continuous run.
- R2: The effective prescale value is the input with bit 0 forced to zero, and an input of 0 or 1 acts as 2. For example, inputs 3 and 2 give the same timing, and inputs 0 and 1 give the same timing as 2.
- R3: The serial clock idles low and has an even duty cycle of H = P*(R+1)/2 low cycles followed by H high cycles. Counting the first rising core edge with enable high as edge 1, the level first rises on edge H.
- R4: `sclk_rise` is high for exactly the one cycle in which `sclk` has just gone from 0 to 1. `sclk_fall` is high for exactly the one cycle in which `sclk` has just gone from 1 to 0. The two strobes are never high together.
- R5: `bit_tick` is high for one cycle per serial period, in the cycle in which the period ends (together with the falling strobe).
- R6: When enable is sampled low, the following cycle shows `sclk`, `sclk_rise`, `sclk_fall` and `bit_tick` all at 0, and they stay at 0 while enable is low. On re-enable, the timing restarts from edge 1 as in R3.
- R7: Divisor inputs that change while enabled are used only from the end of the current full period. The period in progress keeps its old length.
- R8: The extremes work as specified: prescale 2 with rate 0 gives a period of 2 core cycles, and prescale 254 with rate 255 gives 65024 core cycles.
- R9: While reset is active, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Run enable; low holds idle and clears counters |
| prescale_i | input | 8 | Prescale divisor; bit 0 ignored, 0 acts as 2 |
| rate_i | input | 8 | Serial clock rate; second stage divides by rate_i+1 |
| sclk | output | 1 | Generated serial clock level, idle low |
| sclk_rise | output | 1 | One-cycle strobe on the serial clock rising edge |
| sclk_fall | output | 1 | One-cycle strobe on the serial clock falling edge |
| bit_tick | output | 1 | One-cycle strobe at the end of each serial period |

## Verification
All four outputs are registered, so each event shows one edge after the counters reach their terminal values. The first rise appears in the cycle after enabled edge H, and the first fall and tick appear in the cycle after edge 2H. Disabling shows its effect one edge after enable is sampled low. The bench samples two nanoseconds after every rising edge and indexes each sample by the count of enabled edges. It compares all four outputs against a level and strobe pattern computed arithmetically from P and R for that same index, over a sweep of prescale and rate values, the two extremes, a mid-period divisor change and a disable/re-enable sequence.

// File: rtl/serial_rate_pkg.sv
package serial_rate_pkg;

  typedef enum logic {
    PH_LOW  = 1'b0,
    PH_HIGH = 1'b1
  } sclk_phase_e;

endpackage

// File: rtl/rate_cfg_hold.sv
module rate_cfg_hold #(
  parameter int PRE_W  = 8,
  parameter int RATE_W = 8,
  localparam int HALF_W = PRE_W - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              period_end,
  input  logic [PRE_W-1:0]  prescale_i,
  input  logic [RATE_W-1:0] rate_i,
  output logic [HALF_W-1:0] half_pre,
  output logic [RATE_W-1:0] rate
);

  localparam logic [HALF_W-1:0] HALF_ONE = HALF_W'(1);

  logic [HALF_W-1:0] half_in;
  logic              lsb_unused;

  // Half of the even divisor; zero is promoted to one (divisor 2).
  assign lsb_unused = prescale_i[0];

  always_comb begin
    half_in = prescale_i[PRE_W-1:1];
    if (half_in == '0) half_in = HALF_ONE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      half_pre <= HALF_ONE;
      rate     <= '0;
    end else if (!en || period_end) begin
      half_pre <= half_in;
      rate     <= rate_i;
    end
  end

  // R2: the half divisor never reaches zero
  assert_half_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    half_pre != '0);

  // R7: no reload unless disabled or a full period just closed
  assert_cfg_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(en) && !$past(period_end)) |-> ($stable(half_pre) && $stable(rate)));

endmodule

// File: rtl/rate_prescale.sv
module rate_prescale #(
  parameter int HALF_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [HALF_W-1:0] half_pre,
  output logic              pre_tick
);

  logic [HALF_W-1:0] cnt_q;

  assign pre_tick = en && (cnt_q == half_pre - HALF_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n || !en) cnt_q <= '0;
    else if (pre_tick) cnt_q <= '0;
    else               cnt_q <= cnt_q + HALF_W'(1);
  end

  // R1: first-stage count stays below its terminal value
  assert_pre_in_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> (cnt_q < half_pre));

endmodule

// File: rtl/rate_divider.sv
module rate_divider #(
  parameter int RATE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              pre_tick,
  input  logic [RATE_W-1:0] rate,
  output logic              half_end
);

  logic [RATE_W-1:0] cnt_q;

  assign half_end = pre_tick && (cnt_q == rate);

  always_ff @(posedge clk) begin
    if (!rst_n || !en)  cnt_q <= '0;
    else if (half_end)  cnt_q <= '0;
    else if (pre_tick)  cnt_q <= cnt_q + RATE_W'(1);
  end

  // R1: second-stage count never passes the rate value
  assert_rate_in_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> (cnt_q <= rate));

endmodule

// File: rtl/rate_edge_gen.sv
module rate_edge_gen
  import serial_rate_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic half_end,
  output logic period_end,
  output logic sclk,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic bit_tick
);

  sclk_phase_e phase_q;

  assign period_end = half_end && (phase_q == PH_HIGH);
  assign sclk       = (phase_q == PH_HIGH);

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      phase_q   <= PH_LOW;
      sclk_rise <= 1'b0;
      sclk_fall <= 1'b0;
      bit_tick  <= 1'b0;
    end else begin
      sclk_rise <= half_end && (phase_q == PH_LOW);
      sclk_fall <= period_end;
      bit_tick  <= period_end;
      if (half_end) phase_q <= (phase_q == PH_LOW) ? PH_HIGH : PH_LOW;
    end
  end

  // R4: strobes are exclusive
  assert_strobe_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(sclk_rise && sclk_fall));

  // R4: a rise strobe marks a fresh 0->1 level change
  assert_rise_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_rise |-> (sclk && !$past(sclk)));

  // R5: the period tick lands on a 1->0 level change
  assert_tick_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |-> (!sclk && $past(sclk)));

  // R6: disable forces idle on the next cycle
  assert_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!sclk && !sclk_rise && !sclk_fall && !bit_tick));

endmodule

// File: rtl/serial_rate_gen.sv
module serial_rate_gen #(
  parameter int PRE_W  = 8,
  parameter int RATE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [PRE_W-1:0]  prescale_i,
  input  logic [RATE_W-1:0] rate_i,
  output logic              sclk,
  output logic              sclk_rise,
  output logic              sclk_fall,
  output logic              bit_tick
);

  localparam int HALF_W = PRE_W - 1;

  logic [HALF_W-1:0] half_pre;
  logic [RATE_W-1:0] rate;
  logic              pre_tick;
  logic              half_end;
  logic              period_end;

  rate_cfg_hold #(.PRE_W(PRE_W), .RATE_W(RATE_W)) u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .period_end (period_end),
    .prescale_i (prescale_i),
    .rate_i     (rate_i),
    .half_pre   (half_pre),
    .rate       (rate)
  );

  rate_prescale #(.HALF_W(HALF_W)) u_pre (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .half_pre (half_pre),
    .pre_tick (pre_tick)
  );

  rate_divider #(.RATE_W(RATE_W)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .pre_tick (pre_tick),
    .rate     (rate),
    .half_end (half_end)
  );

  rate_edge_gen u_edge (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .half_end   (half_end),
    .period_end (period_end),
    .sclk       (sclk),
    .sclk_rise  (sclk_rise),
    .sclk_fall  (sclk_fall),
    .bit_tick   (bit_tick)
  );

  // R9: outputs quiet while reset is held
  assert_reset_quiet_R9: assert property (@(posedge clk)
    $past(!rst_n) |-> (!sclk && !sclk_rise && !sclk_fall && !bit_tick));

endmodule

// File: tb/tb_serial_rate_gen.sv
module tb_serial_rate_gen;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       en;
  logic [7:0] prescale_i;
  logic [7:0] rate_i;
  logic       sclk, sclk_rise, sclk_fall, bit_tick;

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  serial_rate_gen dut (
    .clk(clk), .rst_n(rst_n), .en(en), .prescale_i(prescale_i),
    .rate_i(rate_i), .sclk(sclk), .sclk_rise(sclk_rise),
    .sclk_fall(sclk_fall), .bit_tick(bit_tick)
  );

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  function automatic int eff_pre(input int p);
    int e;
    e = p & 32'hFE;
    return (e == 0) ? 2 : e;
  endfunction

  // expected {sclk, rise, fall, tick} after enabled edge k with half period h
  function automatic logic [3:0] expect_at(input int k, input int h);
    int q;
    logic edge_now;
    q = k / h;
    edge_now = (k % h) == 0;
    return {q[0], edge_now && q[0], edge_now && !q[0], edge_now && !q[0]};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // compares cycles 1..ncyc of a run that was just enabled
  task automatic run_compare(input int h, input int ncyc, input string req,
                             input string what);
    int bad = 0;
    int bad_k = 0;
    logic [3:0] got = '0;
    logic [3:0] want = '0;
    for (int k = 1; k <= ncyc; k++) begin
      step();
      if ({sclk, sclk_rise, sclk_fall, bit_tick} != expect_at(k, h) && bad == 0) begin
        bad_k = k;
        got  = {sclk, sclk_rise, sclk_fall, bit_tick};
        want = expect_at(k, h);
      end
      if ({sclk, sclk_rise, sclk_fall, bit_tick} != expect_at(k, h)) bad++;
    end
    check(bad == 0, req, $sformatf("%s first-mismatch-cycle=%0d", what, bad_k),
          int'(got), int'(want));
  endtask

  task automatic setup_cfg(input int p, input int r);
    en = 1'b0;
    prescale_i = 8'(p);
    rate_i = 8'(r);
    step();
    step();
  endtask

  task automatic run_cfg(input int p, input int r, input int periods, input string req);
    int n;
    n = eff_pre(p) * (r + 1);
    setup_cfg(p, r);
    en = 1'b1;
    run_compare(n / 2, n * periods, req, $sformatf("p=%0d r=%0d", p, r));
    en = 1'b0;
  endtask

  initial begin
    int plist [9] = '{0, 1, 2, 3, 4, 5, 8, 13, 254};
    int rlist [4] = '{0, 1, 3, 7};
    int nrise;
    int nrise_exp;
    rst_n = 1'b0;
    en = 1'b0;
    prescale_i = 8'd4;
    rate_i = 8'd0;
    for (int i = 0; i < 4; i++) step();
    // R9: reset state
    check({sclk, sclk_rise, sclk_fall, bit_tick} == 4'b0, "R9", "reset outputs",
          int'({sclk, sclk_rise, sclk_fall, bit_tick}), 0);
    rst_n = 1'b1;
    step();

    // R1 R3 R4 R5 R2: sweep of prescale and rate values
    foreach (plist[i]) begin
      foreach (rlist[j]) begin
        run_cfg(plist[i], rlist[j], 2, "R1/R3/R4/R5");
      end
    end
    // R2: odd and zero prescale behave as the even value below (0,1 -> 2)
    run_cfg(1, 2, 3, "R2");
    run_cfg(7, 1, 3, "R2");

    // R8: fastest and slowest settings
    run_cfg(2, 0, 8, "R8");
    run_cfg(2, 255, 2, "R8");
    run_cfg(254, 255, 1, "R8");

    // R6: disable mid-period, stays idle, then restarts from edge 1
    setup_cfg(6, 1);
    en = 1'b1;
    for (int k = 1; k <= 8; k++) step();
    check(sclk == 1'b1, "R6", "level high before disable", int'(sclk), 1);
    en = 1'b0;
    nrise = 0;
    for (int k = 0; k < 5; k++) begin
      step();
      if ({sclk, sclk_rise, sclk_fall, bit_tick} != 4'b0) nrise++;
    end
    check(nrise == 0, "R6", "cycles not idle while disabled", nrise, 0);
    en = 1'b1;
    run_compare(6, 36, "R6", "restart after re-enable");
    en = 1'b0;

    // R7: change divisors mid-period; old period finishes (12), then 2-cycle periods
    setup_cfg(4, 2);
    en = 1'b1;
    for (int k = 1; k <= 3; k++) step();
    prescale_i = 8'd2;
    rate_i = 8'd0;
    nrise = 0;
    for (int k = 4; k <= 20; k++) begin
      logic [3:0] want;
      step();
      want = (k <= 12) ? expect_at(k, 6) : expect_at(k - 12, 1);
      if ({sclk, sclk_rise, sclk_fall, bit_tick} != want) nrise++;
    end
    check(nrise == 0, "R7", "mismatching cycles across divisor change", nrise, 0);
    en = 1'b0;

    // R5: tick count over a long run equals the number of periods
    setup_cfg(10, 2);
    en = 1'b1;
    nrise = 0;
    nrise_exp = 0;
    for (int k = 1; k <= 300; k++) begin
      step();
      if (bit_tick) nrise++;
      if (sclk_rise) nrise_exp++;
    end
    check(nrise == 10, "R5", "bit_tick count over 10 periods", nrise, 10);
    check(nrise_exp == 10, "R4", "rise strobe count over 10 periods", nrise_exp, 10);
    en = 1'b0;
    step();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    wait (cyc >= 190000);
    failures++;
    checks++;
    $display("FAIL watchdog run did not finish actual=%0d expected=<190000", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule